// File: doc/BRIEF.md
# Local Interrupt Controller Register Write Logic

This block is the register file of a per-core interrupt controller, reached through a single indexed access port. It has the following registers:

- six local vector entries, one each for the timer, thermal sensor, performance counters, local line 0, local line 1 and the error source;
- a spurious-vector register;
- an error-status register;
- a constant version register;
- a small internal state word.

A write does not always store its value unchanged. Each register has its own write mask and its own effect on the state word, and one register also changes the state word when it is read.

Read data and a read-valid pulse appear one cycle after a read strobe. Every other index in the address space answers with a one-cycle error pulse. These other indices include the priority, end-of-interrupt, destination, command and timer-count slots, and the three 16-word in-service, trigger-mode and request arrays. Such an access leaves all storage untouched.

Top module: `intc_local_regs`

## Requirements
- R1: While rstN is low and after its release, every stored register and the state word read as 0, and rdValid and accessErr are 0.
- R2: A cycle with rdEn=1 and wrEn=0 gives rdValid=1 on the next cycle, with rdData holding the addressed value. Index 0x00 always reads the VERSION_VALUE parameter (default 0x0006_0011).
- R3: The six vector entries sit at indices 0x08 to 0x0D, in the order timer, thermal, performance, line 0, line 1, error. A write stores wdata except bits 12 and 14, which keep their previous value.
- R4: A write to the spurious-vector register (0x02) stores wdata. It also clears state bit 1 and sets state bit 8 (the software enable) to wdata bit 8.
- R5: A read of the error-status register (0x03) returns its stored value and clears state bit 0 on the same edge.
- R6: A write to the error-status register stores wdata and inverts state bit 0. Successive writes therefore alternately arm and disarm error latching.
- R7: A write to the version register (0x00) or to the state register (0x01) pulses accessErr and changes neither register.
- R8: Any read or write at an index other than 0x00 to 0x03 and 0x08 to 0x0D pulses accessErr on the next cycle. Such an access changes no register, and a read of this kind returns rdData=0 with rdValid=1.
- R9: accessErr is high for exactly the cycle after each illegal access and stays low after legal ones.
- R10: When wrEn and rdEn are both high, only the write takes place. rdValid stays low and no read side effect occurs.
- R11: The state word reads back at index 0x01, zero-extended, with bit 0 as the error arm, bit 1 as the spurious-write flag and bit 8 as the software enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 7 | Register index |
| wdata | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Pulses one cycle after a read |
| accessErr | output | 1 | Pulses one cycle after an illegal access |

## Verification
The bench writes all ones to a vector entry and expects bits 12 and 14 to read back as zero. A design that fails to protect those bits would return them set. It writes the error-status register several times in a row and reads the state word after each write, so a design that sets bit 0 instead of toggling it would leave that bit stuck at 1. A read of the error-status register followed by a state read catches a missing clear-on-read. A read of the error-status register issued together with a write to it catches a read side effect that fires when it should not. Accesses to every unimplemented range are each followed by read-backs of the stored registers, so a decode that lets such an access through would show up as corrupted data or a missing error pulse.

// File: rtl/intc_regs_pkg.sv
package intc_regs_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 7;
  localparam int NUM_LVT    = 6;
  localparam int LVT_IDX_W  = $clog2(NUM_LVT);
  localparam int STATE_W    = 9;

  localparam logic [ADDR_W-1:0] IDX_VERSION = 7'h00;
  localparam logic [ADDR_W-1:0] IDX_STATE   = 7'h01;
  localparam logic [ADDR_W-1:0] IDX_SPUR    = 7'h02;
  localparam logic [ADDR_W-1:0] IDX_ESR     = 7'h03;
  localparam logic [ADDR_W-1:0] IDX_LVT0    = 7'h08;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_VERSION, SEL_STATE, SEL_SPUR, SEL_ESR, SEL_LVT
  } rdSel_e;

  typedef struct packed {
    logic                 rdEn;
    rdSel_e               rdSel;
    logic [LVT_IDX_W-1:0] lvtIdx;
    logic                 lvtWr;
    logic                 spurWr;
    logic                 esrWr;
    logic                 esrRd;
    logic                 err;
  } strobe_t;
endpackage

// File: rtl/intc_regs_ctrl.sv
module intc_regs_ctrl
  import intc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic              accessErr
);
  logic              isRd;
  logic              bad;
  logic              lvtHit;
  logic [ADDR_W-1:0] lvtOff;

  assign isRd   = rdEn & ~wrEn;
  assign lvtOff = addr - IDX_LVT0;
  assign lvtHit = (addr >= IDX_LVT0) && (lvtOff < ADDR_W'(NUM_LVT));

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    bad        = 1'b0;
    strb.rdEn  = isRd;
    if (addr == IDX_VERSION) begin
      if (wrEn) bad = 1'b1;
      else      strb.rdSel = SEL_VERSION;
    end else if (addr == IDX_STATE) begin
      if (wrEn) bad = 1'b1;
      else      strb.rdSel = SEL_STATE;
    end else if (addr == IDX_SPUR) begin
      strb.spurWr = wrEn;
      strb.rdSel  = SEL_SPUR;
    end else if (addr == IDX_ESR) begin
      strb.esrWr = wrEn;
      strb.esrRd = isRd;
      strb.rdSel = SEL_ESR;
    end else if (lvtHit) begin
      strb.lvtWr  = wrEn;
      strb.lvtIdx = lvtOff[LVT_IDX_W-1:0];
      strb.rdSel  = SEL_LVT;
    end else begin
      bad = 1'b1;
    end
    strb.err = bad & (wrEn | rdEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accessErr <= 1'b0;
    else       accessErr <= strb.err;
  end

  // R9: an error pulse only follows an access strobe
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(wrEn | rdEn));
  // R8: an access at the first unused index after the vector entries is flagged
  assert_unmapped_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((wrEn | rdEn) && addr == IDX_LVT0 + ADDR_W'(NUM_LVT)) |=> accessErr);
endmodule

// File: rtl/intc_regs_dp.sv
module intc_regs_dp
  import intc_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION_VALUE = 32'h0006_0011,
  parameter logic [DATA_W-1:0] RO_MASK       = 32'h0000_5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [NUM_LVT-1:0][DATA_W-1:0] lvtVal;
  logic [DATA_W-1:0]              spurReg;
  logic [DATA_W-1:0]              esrReg;
  logic [STATE_W-1:0]             stateReg;
  logic [DATA_W-1:0]              lvtRd;
  logic [DATA_W-1:0]              rdNext;

  for (genvar g = 0; g < NUM_LVT; g++) begin : gLvt
    logic [DATA_W-1:0] entry;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        entry <= '0;
      else if (strb.lvtWr && strb.lvtIdx == LVT_IDX_W'(g))
        entry <= (wdata & ~RO_MASK) | (entry & RO_MASK);
    end
    assign lvtVal[g] = entry;

    // R3: status bits survive a write
    assert_lvt_ro_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.lvtWr && strb.lvtIdx == LVT_IDX_W'(g)) |=>
        ((entry & RO_MASK) == $past(entry & RO_MASK)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spurReg <= '0;
      esrReg  <= '0;
    end else begin
      if (strb.spurWr) spurReg <= wdata;
      if (strb.esrWr)  esrReg  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg <= '0;
    end else begin
      if (strb.esrWr)      stateReg[0] <= ~stateReg[0];
      else if (strb.esrRd) stateReg[0] <= 1'b0;
      if (strb.spurWr) begin
        stateReg[1] <= 1'b0;
        stateReg[8] <= wdata[8];
      end
    end
  end

  always_comb begin
    lvtRd = '0;
    for (int i = 0; i < NUM_LVT; i++)
      if (strb.lvtIdx == LVT_IDX_W'(i)) lvtRd = lvtVal[i];
  end

  always_comb begin
    case (strb.rdSel)
      SEL_VERSION: rdNext = VERSION_VALUE;
      SEL_STATE:   rdNext = DATA_W'(stateReg);
      SEL_SPUR:    rdNext = spurReg;
      SEL_ESR:     rdNext = esrReg;
      SEL_LVT:     rdNext = lvtRd;
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= rdNext;
    end
  end

  // R2: read data one cycle after the strobe
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> rdValid);
  // R6: each error-status write inverts the arm bit
  assert_esr_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.esrWr |=> (stateReg[0] != $past(stateReg[0])));
  // R5: an error-status read disarms
  assert_esr_rdclr_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.esrRd |=> !stateReg[0]);
  // R4: the spurious write sets the enable from data bit 8
  assert_spur_en_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.spurWr |=> (stateReg[8] == $past(wdata[8]) && !stateReg[1]));
endmodule

// File: rtl/intc_local_regs.sv
module intc_local_regs
  import intc_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION_VALUE = 32'h0006_0011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              accessErr
);
  strobe_t strb;

  intc_regs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .strb(strb), .accessErr(accessErr)
  );

  intc_regs_dp #(.VERSION_VALUE(VERSION_VALUE)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(wdata),
    .rdData(rdData), .rdValid(rdValid)
  );

  // R10: a combined strobe never yields read data
  assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |=> !rdValid);
endmodule

// File: tb/sim_intc_local_regs.sv
module sim_intc_local_regs;
  localparam logic [31:0] VER = 32'h0006_0011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        accessErr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic        valid;
    logic [31:0] data;
    logic        err;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  intc_local_regs #(.VERSION_VALUE(VER)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdData(rdData), .rdValid(rdValid), .accessErr(accessErr)
  );

  task automatic access(input logic w, input logic r, input logic [6:0] a,
                        input logic [31:0] d, input logic ev,
                        input logic [31:0] ed, input logic ee, input string tag);
    item_t it;
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wdata = d;
    it.due = cyc + 1; it.valid = ev; it.data = ed; it.err = ee; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic ee, input string tag);
    access(1'b1, 1'b0, a, d, 1'b0, 32'h0, ee, tag);
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] ed, input logic ee, input string tag);
    access(1'b0, 1'b1, a, 32'h0, 1'b1, ed, ee, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b0; rdEn = 1'b0;
    end
  endtask

  // monitor: pops expected items as their cycle arrives
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (rdValid !== it.valid || accessErr !== it.err ||
          (it.valid && rdData !== it.data)) begin
        errors++;
        $display("FAIL %s: valid=%0b data=%h err=%0b, expected valid=%0b data=%h err=%0b",
                 it.tag, rdValid, rdData, accessErr, it.valid, it.data, it.err);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rdValid !== 1'b0 || accessErr !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: valid=%0b err=%0b expected 0 0", rdValid, accessErr);
    end
    rstN = 1'b1;
    idle(1);

    // R1 reset values, R2 version read
    rd(7'h01, 32'h0, 1'b0, "R1 state");
    rd(7'h02, 32'h0, 1'b0, "R1 spurious");
    rd(7'h03, 32'h0, 1'b0, "R1 esr");
    for (int k = 0; k < 6; k++) rd(7'h08 + 7'(k), 32'h0, 1'b0, "R1 vector");
    rd(7'h00, VER, 1'b0, "R2 version");

    // R3 masking
    wr(7'h08, 32'hFFFF_FFFF, 1'b0, "R3 write ones");
    rd(7'h08, 32'hFFFF_AFFF, 1'b0, "R3 ro bits");
    rd(7'h09, 32'h0, 1'b0, "R3 neighbour");
    for (int k = 0; k < 6; k++)
      wr(7'h08 + 7'(k), 32'hA000_70FF + (32'(k) << 24), 1'b0, "R3 write");
    for (int k = 0; k < 6; k++)
      rd(7'h08 + 7'(k), 32'hA000_20FF + (32'(k) << 24), 1'b0, "R3 readback");

    // R4 spurious, R11 state layout
    wr(7'h02, 32'h0000_01FF, 1'b0, "R4 spur wr");
    rd(7'h01, 32'h0000_0100, 1'b0, "R4 R11 enable set");
    rd(7'h02, 32'h0000_01FF, 1'b0, "R4 spur rd");
    wr(7'h02, 32'h0000_00FF, 1'b0, "R4 spur wr2");
    rd(7'h01, 32'h0, 1'b0, "R4 enable clear");

    // R6 toggling
    wr(7'h03, 32'h11, 1'b0, "R6 esr wr1");
    rd(7'h01, 32'h1, 1'b0, "R6 armed");
    wr(7'h03, 32'h22, 1'b0, "R6 esr wr2");
    rd(7'h01, 32'h0, 1'b0, "R6 disarmed");
    wr(7'h03, 32'h33, 1'b0, "R6 esr wr3");
    rd(7'h01, 32'h1, 1'b0, "R6 rearmed");

    // R5 read clear
    rd(7'h03, 32'h33, 1'b0, "R5 esr value");
    rd(7'h01, 32'h0, 1'b0, "R5 cleared");

    // R7 read-only registers
    wr(7'h00, 32'hFFFF_FFFF, 1'b1, "R7 version wr");
    rd(7'h00, VER, 1'b0, "R7 version kept");
    wr(7'h01, 32'hFFFF_FFFF, 1'b1, "R7 state wr");
    rd(7'h01, 32'h0, 1'b0, "R7 state kept");

    // R8 unimplemented / unmapped, R9 pulse
    rd(7'h04, 32'h0, 1'b1, "R8 priority rd");
    wr(7'h07, 32'hFFFF_FFFF, 1'b1, "R8 eoi wr");
    wr(7'h12, 32'hFFFF_FFFF, 1'b1, "R8 count wr");
    rd(7'h25, 32'h0, 1'b1, "R8 in-service rd");
    wr(7'h3F, 32'hFFFF_FFFF, 1'b1, "R8 trigger wr");
    wr(7'h4F, 32'hFFFF_FFFF, 1'b1, "R8 request wr");
    wr(7'h0E, 32'hFFFF_FFFF, 1'b1, "R8 past vectors");
    rd(7'h7F, 32'h0, 1'b1, "R8 top index");
    rd(7'h0D, 32'hA500_20FF, 1'b0, "R8 R9 vector intact");
    rd(7'h02, 32'h0000_00FF, 1'b0, "R8 spurious intact");
    rd(7'h03, 32'h33, 1'b0, "R8 esr intact");

    // R10 combined strobe
    access(1'b1, 1'b1, 7'h02, 32'h0000_0100, 1'b0, 32'h0, 1'b0, "R10 spur rdwr");
    rd(7'h02, 32'h0000_0100, 1'b0, "R10 write took");
    access(1'b1, 1'b1, 7'h03, 32'h44, 1'b0, 32'h0, 1'b0, "R10 esr rdwr");
    rd(7'h01, 32'h0000_0101, 1'b0, "R10 R11 no read clear");

    idle(4);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule